// File: doc/BRIEF.md
# PCIe Programmed-IO Memory Endpoint

This block is a small memory target that sits on the transaction-layer streams of a PCIe endpoint. It watches the 64-bit receive stream for 32-bit-address memory requests, stores single-doubleword writes into an internal 8 KB array, and answers single-doubleword reads with a completion-with-data packet on the 64-bit transmit stream. Both streams are framed with active-low start, end, source-ready and destination-ready strobes, plus an 8-bit active-low remainder.

Headers travel most-significant doubleword first. On a beat, header doubleword 0 is in bits [63:32] and doubleword 1 in bits [31:0]. The second beat carries header doubleword 2 in [63:32] and, for a write, the payload in [31:0]. A read completion is also sent as two beats. Only one read may be outstanding at a time. The block holds off the receive stream until the completion of the current read has left, and it marks the start and the end of each completion with one-cycle pulses.

Top module: `pio_mem_target`

## Requirements
- R1: While `linkUpN` is high, the block is held in reset. In reset and on release, `txSrcRdyN` is 1, `rxDstRdyN` is 0, and `reqCompl` and `complDone` are 0. The link going down in the middle of a completion abandons it, and the memory contents are kept.
- R2: The memory holds 2048 doublewords, selected by request address bits [12:2]. Address bits 31:13 are ignored. An accepted write (header DW0 bits [30:24] = 0x40, length field [9:0] = 1) stores its payload into the selected word.
- R3: Bit i of the first-DW byte enable (header DW1 bits [3:0]) enables payload bits [8i+7:8i]. All other bytes of the word keep their old value.
- R4: A read request (DW0 bits [30:24] = 0x00, length 1) whose second beat ends the frame gets a completion of exactly two beats. The first beat has `txSofN` low and the second beat has `txEofN` low. `txRemN` is 0x00 on both beats, and the data doubleword of the second beat is the stored word.
- R5: Completion DW0 has format/type 0x4A in bits [30:24] and length 1. Its traffic class [22:20] and attributes [13:12] are copied from the request. DW1 has `complId` in [31:16], status 0 in [15:13] and byte count 4 in [11:0].
- R6: Completion DW2 carries the requester ID [31:16] and tag [15:8] copied from the request. Its lower address [6:0] is request address bits [6:2] followed by the byte offset of the lowest enabled first-DW byte (0 when no byte is enabled).
- R7: The block consumes every beat of a packet up to its end of frame, but drops the packet without any effect on memory or the transmit stream in these cases: no bit of `rxBarHitN` is low, another format/type, a length other than 1, a read whose second beat does not end the frame, or a write whose second beat has `rxRemN` other than 0x00.
- R8: `rxDstRdyN` is high from the cycle after a read is accepted through the cycle of the final completion handshake. It is low again in the cycle after that handshake.
- R9: While `txSrcRdyN` is low and `txDstRdyN` is high, `txData` and the framing outputs hold. A beat advances only on a cycle where both are low.
- R10: `reqCompl` is high for exactly one cycle, the first cycle the completion's first beat is presented. `complDone` is high for exactly one cycle, the cycle after the final beat's handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| linkUpN | input | 1 | Link-up indication, active low; high holds the block in reset |
| rxData | input | 64 | Receive beat data |
| rxRemN | input | 8 | Receive remainder, active low per byte |
| rxSofN | input | 1 | Receive start of frame, active low |
| rxEofN | input | 1 | Receive end of frame, active low |
| rxSrcRdyN | input | 1 | Receive beat valid, active low |
| rxBarHitN | input | 7 | BAR hit vector, active low per BAR |
| rxDstRdyN | output | 1 | Block ready to take a receive beat, active low |
| txData | output | 64 | Transmit beat data |
| txRemN | output | 8 | Transmit remainder, active low per byte |
| txSofN | output | 1 | Transmit start of frame, active low |
| txEofN | output | 1 | Transmit end of frame, active low |
| txSrcRdyN | output | 1 | Transmit beat valid, active low |
| txDstRdyN | input | 1 | Link ready to take a transmit beat, active low |
| complId | input | 16 | Completer ID placed in every completion |
| reqCompl | output | 1 | One-cycle pulse when a completion starts |
| complDone | output | 1 | One-cycle pulse after a completion finishes |

## Verification
On every cycle, the assertions check the transmit-hold rule under backpressure, the timing of the request and done pulses against the frame handshakes, and that no memory write happens while a completion is in flight. The correctness of header fields, byte merging, address aliasing, lower-address adjustment and packet dropping depends on the contents of whole transactions. Only the bench's scenarios can show these, by comparing each completion with a reference memory model. Dropped packets are shown to be harmless by reading the affected words back afterwards.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam logic [6:0] FT_MRD32 = 7'h00;
  localparam logic [6:0] FT_MWR32 = 7'h40;
  localparam logic [6:0] FT_CPLD  = 7'h4A;

  typedef enum logic [1:0] {KIND_DROP, KIND_WR, KIND_RD} reqKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capHdr;   // latch header DW0/DW1 fields
    logic memWr;    // commit write payload
    logic capRd;    // latch read address, start completion
    logic selTail;  // present second completion beat
  } pioStrobe_t;
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int BAR_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [63:0]      rxData,
  input  logic [7:0]       rxRemN,
  input  logic             rxSofN,
  input  logic             rxEofN,
  input  logic             rxSrcRdyN,
  input  logic [BAR_W-1:0] rxBarHitN,
  output logic             rxDstRdyN,
  input  logic             txDstRdyN,
  output logic             txSofN,
  output logic             txEofN,
  output logic             txSrcRdyN,
  output logic [7:0]       txRemN,
  output logic             reqCompl,
  output logic             complDone,
  output pioStrobe_t       stb
);
  typedef enum logic [1:0] {RX_IDLE, RX_SECOND, RX_DRAIN} rxState_t;
  typedef enum logic [1:0] {TX_IDLE, TX_HEAD, TX_TAIL} txState_t;

  rxState_t rxState, rxNext;
  txState_t txState, txNext;
  reqKind_t kindQ, newKind;
  logic     rxTake, txTake, barHit, lenOne, tailDone;
  logic     unusedHdr;

  assign unusedHdr = ^rxData;
  assign barHit    = (rxBarHitN != {BAR_W{1'b1}});
  assign lenOne    = (rxData[41:32] == 10'd1);

  always_comb begin
    newKind = KIND_DROP;
    if (barHit && lenOne) begin
      if (rxData[62:56] == FT_MWR32)      newKind = KIND_WR;
      else if (rxData[62:56] == FT_MRD32) newKind = KIND_RD;
    end
  end

  assign rxDstRdyN = (txState != TX_IDLE);
  assign rxTake    = !rxSrcRdyN && !rxDstRdyN;
  assign txSrcRdyN = (txState == TX_IDLE);
  assign txSofN    = (txState != TX_HEAD);
  assign txEofN    = (txState != TX_TAIL);
  assign txRemN    = 8'h00;
  assign txTake    = !txSrcRdyN && !txDstRdyN;
  assign tailDone  = txTake && (txState == TX_TAIL);

  always_comb begin
    rxNext      = rxState;
    stb         = '0;
    stb.selTail = (txState == TX_TAIL);
    case (rxState)
      RX_IDLE: if (rxTake && !rxSofN) begin
        stb.capHdr = 1'b1;
        if (rxEofN) rxNext = (newKind == KIND_DROP) ? RX_DRAIN : RX_SECOND;
      end
      RX_SECOND: if (rxTake) begin
        stb.memWr = (kindQ == KIND_WR) && (rxRemN == 8'h00);
        stb.capRd = (kindQ == KIND_RD) && !rxEofN;
        rxNext    = rxEofN ? RX_DRAIN : RX_IDLE;
      end
      default: if (rxTake && !rxEofN) rxNext = RX_IDLE;
    endcase
  end

  always_comb begin
    txNext = txState;
    case (txState)
      TX_IDLE: if (stb.capRd) txNext = TX_HEAD;
      TX_HEAD: if (txTake)    txNext = TX_TAIL;
      default: if (txTake)    txNext = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rxState   <= RX_IDLE;
      txState   <= TX_IDLE;
      kindQ     <= KIND_DROP;
      reqCompl  <= 1'b0;
      complDone <= 1'b0;
    end else begin
      rxState   <= rxNext;
      txState   <= txNext;
      if (stb.capHdr) kindQ <= newKind;
      reqCompl  <= stb.capRd;
      complDone <= tailDone;
    end
  end

  // R2: no memory write can slip in while a completion is in flight
  a_r2_no_write_in_flight: assert property (@(posedge clk) disable iff (rst)
    stb.memWr |-> txSrcRdyN);
  // R10: request pulse coincides with the first completion beat
  a_r10_req_on_head: assert property (@(posedge clk) disable iff (rst)
    reqCompl |-> (!txSofN && !txSrcRdyN));
  // R10: done pulse follows the final beat handshake
  a_r10_done_after_eof: assert property (@(posedge clk) disable iff (rst)
    complDone |-> $past(!txEofN && !txDstRdyN && !txSrcRdyN));
  // R9: framing holds while the link stalls
  a_r9_frame_hold: assert property (@(posedge clk) disable iff (rst)
    (!txSrcRdyN && txDstRdyN) |=> (!txSrcRdyN && $stable(txSofN) && $stable(txEofN)));
endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int MEM_WORDS = 2048,
  parameter int IDX_W     = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  pioStrobe_t  stb,
  input  logic [63:0] rxData,
  input  logic [15:0] complId,
  output logic [63:0] txData
);
  localparam int IDX_LO = 34;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic [31:0]      mem [MEM_WORDS];
  logic [2:0]       tcQ;
  logic [1:0]       attrQ;
  logic [15:0]      reqIdQ;
  logic [7:0]       tagQ;
  logic [3:0]       fbeQ;
  logic [IDX_W-1:0] rdIdx;
  logic [6:0]       lowAddrQ;
  logic [31:0]      rdWord, cplDw0, cplDw1, cplDw2;
  logic [1:0]       beOffset;
  logic             unusedRx;

  assign unusedRx = ^rxData;

  always_comb begin
    casez (fbeQ)
      4'b???1: beOffset = 2'd0;
      4'b??10: beOffset = 2'd1;
      4'b?100: beOffset = 2'd2;
      4'b1000: beOffset = 2'd3;
      default: beOffset = 2'd0;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      tcQ      <= '0;
      attrQ    <= '0;
      reqIdQ   <= '0;
      tagQ     <= '0;
      fbeQ     <= '0;
      rdIdx    <= '0;
      lowAddrQ <= '0;
    end else begin
      if (stb.capHdr) begin
        tcQ    <= rxData[54:52];
        attrQ  <= rxData[45:44];
        reqIdQ <= rxData[31:16];
        tagQ   <= rxData[15:8];
        fbeQ   <= rxData[3:0];
      end
      if (stb.capRd) begin
        rdIdx    <= rxData[IDX_HI:IDX_LO];
        lowAddrQ <= {rxData[38:34], beOffset};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.memWr) begin
      for (int b = 0; b < 4; b++) begin
        if (fbeQ[b]) mem[rxData[IDX_HI:IDX_LO]][8*b +: 8] <= rxData[8*b +: 8];
      end
    end
    rdWord <= mem[rdIdx];
  end

  assign cplDw0 = {1'b0, FT_CPLD, 1'b0, tcQ, 4'b0, 2'b00, attrQ, 2'b00, 10'd1};
  assign cplDw1 = {complId, 3'b000, 1'b0, 12'd4};
  assign cplDw2 = {reqIdQ, tagQ, 1'b0, lowAddrQ};
  assign txData = stb.selTail ? {cplDw2, rdWord} : {cplDw0, cplDw1};

  // R6: the request fields stay put from the read capture to the tail beat
  a_r6_fields_stable: assert property (@(posedge clk) disable iff (rst)
    (stb.selTail && !stb.capHdr) |=> (stb.capHdr || $stable(cplDw2)));
endmodule

// File: rtl/pio_mem_target.sv
module pio_mem_target #(
  parameter int MEM_BYTES = 8192,
  parameter int BAR_W     = 7
) (
  input  logic             clk,
  input  logic             linkUpN,
  input  logic [63:0]      rxData,
  input  logic [7:0]       rxRemN,
  input  logic             rxSofN,
  input  logic             rxEofN,
  input  logic             rxSrcRdyN,
  input  logic [BAR_W-1:0] rxBarHitN,
  output logic             rxDstRdyN,
  output logic [63:0]      txData,
  output logic [7:0]       txRemN,
  output logic             txSofN,
  output logic             txEofN,
  output logic             txSrcRdyN,
  input  logic             txDstRdyN,
  input  logic [15:0]      complId,
  output logic             reqCompl,
  output logic             complDone
);
  import pio_pkg::*;
  localparam int MEM_WORDS = MEM_BYTES / 4;
  localparam int IDX_W     = $clog2(MEM_WORDS);

  pioStrobe_t stb;

  pio_ctrl #(.BAR_W(BAR_W)) u_ctrl (
    .clk(clk), .rst(linkUpN), .rxData(rxData), .rxRemN(rxRemN),
    .rxSofN(rxSofN), .rxEofN(rxEofN), .rxSrcRdyN(rxSrcRdyN),
    .rxBarHitN(rxBarHitN), .rxDstRdyN(rxDstRdyN), .txDstRdyN(txDstRdyN),
    .txSofN(txSofN), .txEofN(txEofN), .txSrcRdyN(txSrcRdyN),
    .txRemN(txRemN), .reqCompl(reqCompl), .complDone(complDone), .stb(stb)
  );

  pio_datapath #(.MEM_WORDS(MEM_WORDS), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst(linkUpN), .stb(stb), .rxData(rxData),
    .complId(complId), .txData(txData)
  );

  // R9: transmit data holds while the link stalls
  a_r9_data_hold: assert property (@(posedge clk) disable iff (linkUpN)
    (!txSrcRdyN && txDstRdyN) |=> $stable(txData));
endmodule

// File: tb/pio_mem_target_test.sv
module pio_mem_target_test;
  logic        clk = 1'b0;
  logic        linkUpN;
  logic [63:0] rxData;
  logic [7:0]  rxRemN;
  logic        rxSofN, rxEofN, rxSrcRdyN;
  logic [6:0]  rxBarHitN;
  logic        rxDstRdyN;
  logic [63:0] txData;
  logic [7:0]  txRemN;
  logic        txSofN, txEofN, txSrcRdyN, txDstRdyN;
  logic [15:0] complId;
  logic        reqCompl, complDone;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [2048];

  always #5 clk = ~clk;

  pio_mem_target uut (
    .clk(clk), .linkUpN(linkUpN), .rxData(rxData), .rxRemN(rxRemN),
    .rxSofN(rxSofN), .rxEofN(rxEofN), .rxSrcRdyN(rxSrcRdyN),
    .rxBarHitN(rxBarHitN), .rxDstRdyN(rxDstRdyN), .txData(txData),
    .txRemN(txRemN), .txSofN(txSofN), .txEofN(txEofN),
    .txSrcRdyN(txSrcRdyN), .txDstRdyN(txDstRdyN), .complId(complId),
    .reqCompl(reqCompl), .complDone(complDone)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr0(input logic [6:0] ft, input logic [2:0] tc,
                                       input logic [1:0] attr, input logic [9:0] len);
    return {1'b0, ft, 1'b0, tc, 4'b0, 2'b00, attr, 2'b00, len};
  endfunction

  function automatic logic [31:0] hdr1(input logic [15:0] rid, input logic [7:0] tag, input logic [3:0] fbe);
    return {rid, tag, 4'h0, fbe};
  endfunction

  function automatic logic [1:0] beOff(input logic [3:0] fbe);
    if (fbe[0]) return 2'd0;
    if (fbe[1]) return 2'd1;
    if (fbe[2]) return 2'd2;
    if (fbe[3]) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] fbe);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (fbe[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic sendBeat(input logic [63:0] d, input logic [7:0] rem, input bit sof, input bit eof);
    rxData = d; rxRemN = rem; rxSofN = !sof; rxEofN = !eof; rxSrcRdyN = 1'b0;
    while (rxDstRdyN) @(negedge clk);
    @(negedge clk);
    rxSrcRdyN = 1'b1; rxSofN = 1'b1; rxEofN = 1'b1;
  endtask

  task automatic doWrite(input logic [31:0] addr, input logic [3:0] fbe, input logic [31:0] data);
    sendBeat({hdr0(7'h40, 3'd0, 2'd0, 10'd1), hdr1(16'h0100, 8'h00, fbe)}, 8'h00, 1, 0);
    sendBeat({addr[31:2], 2'b00, data}, 8'h00, 0, 1);
    model[addr[12:2]] = merge(model[addr[12:2]], data, fbe);
  endtask

  task automatic doRead(input logic [31:0] addr, input logic [3:0] fbe, input logic [15:0] rid,
                        input logic [7:0] tag, input logic [2:0] tc, input logic [1:0] attr,
                        input bit stalls);
    logic [63:0] beats [2];
    logic [63:0] held;
    bit heldV = 0;
    int n = 0;
    int guard = 0;
    logic [31:0] e0, e1, e2;
    sendBeat({hdr0(7'h00, tc, attr, 10'd1), hdr1(rid, tag, fbe)}, 8'h00, 1, 0);
    sendBeat({addr[31:2], 2'b00, 32'h0}, 8'h0F, 0, 1);
    chk(reqCompl === 1'b1, "R10 reqCompl pulse", {63'd0, reqCompl}, 64'd1);
    chk(rxDstRdyN === 1'b1, "R8 rx held off", {63'd0, rxDstRdyN}, 64'd1);
    while (n < 2 && guard < 200) begin
      if (heldV) begin
        chk(txData === held && txSrcRdyN === 1'b0, "R9 hold under stall", txData, held);
        heldV = 0;
      end
      if (n == 1 && guard > 0) chk(reqCompl === 1'b0, "R10 reqCompl single", {63'd0, reqCompl}, 64'd0);
      txDstRdyN = stalls ? ($urandom % 3 == 0) : 1'b0;
      if (!txSrcRdyN) begin
        if (txDstRdyN) begin
          held = txData; heldV = 1;
        end else begin
          chk(txSofN === (n != 0) && txEofN === (n != 1) && txRemN === 8'h00, "R4 framing",
              {54'd0, txRemN, txSofN, txEofN}, {56'd0, 6'd0, n != 0, n != 1});
          beats[n] = txData;
          n++;
        end
      end
      @(negedge clk);
      guard++;
    end
    txDstRdyN = 1'b0;
    chk(complDone === 1'b1, "R10 complDone pulse", {63'd0, complDone}, 64'd1);
    chk(rxDstRdyN === 1'b0 && txSrcRdyN === 1'b1, "R8 rx ready again", {62'd0, rxDstRdyN, txSrcRdyN}, 64'd1);
    e0 = {1'b0, 7'h4A, 1'b0, tc, 4'b0, 2'b00, attr, 2'b00, 10'd1};
    e1 = {complId, 3'b000, 1'b0, 12'd4};
    e2 = {rid, tag, 1'b0, addr[6:2], beOff(fbe)};
    chk(beats[0] === {e0, e1}, "R5 header DW0/DW1", beats[0], {e0, e1});
    chk(beats[1][63:32] === e2, "R6 header DW2", {32'd0, beats[1][63:32]}, {32'd0, e2});
    chk(beats[1][31:0] === model[addr[12:2]], "R2 R3 read data", {32'd0, beats[1][31:0]},
        {32'd0, model[addr[12:2]]});
  endtask

  task automatic expectQuiet(input string req);
    for (int i = 0; i < 3; i++) begin
      chk(txSrcRdyN === 1'b1 && reqCompl === 1'b0 && rxDstRdyN === 1'b0, req,
          {61'd0, txSrcRdyN, reqCompl, rxDstRdyN}, 64'd4);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pool [64];
    void'($urandom(32'd1234));
    linkUpN = 1'b1; rxData = '0; rxRemN = 8'hFF; rxSofN = 1; rxEofN = 1; rxSrcRdyN = 1;
    rxBarHitN = 7'b1111110; txDstRdyN = 1'b0; complId = 16'hBEEF;
    for (int i = 0; i < 2048; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txSrcRdyN === 1'b1 && reqCompl === 1'b0 && complDone === 1'b0 && rxDstRdyN === 1'b0,
        "R1 reset state", {60'd0, txSrcRdyN, reqCompl, complDone, rxDstRdyN}, 64'h8);
    linkUpN = 1'b0;
    @(negedge clk);
    chk(txSrcRdyN === 1'b1 && rxDstRdyN === 1'b0, "R1 after release", {62'd0, txSrcRdyN, rxDstRdyN}, 64'd2);

    // seed a pool of words spread over the array
    for (int i = 0; i < 64; i++) begin
      pool[i] = {$urandom} & 32'hFFFF_E000 | (32'(i) << 7) | (32'(i % 32) << 2);
      doWrite(pool[i], 4'hF, $urandom);
    end
    doRead(pool[5], 4'hF, 16'h1234, 8'h5A, 3'd2, 2'd1, 0);

    // R2 aliasing: bit 13 ignored
    doWrite(32'h0000_2004, 4'hF, 32'hCAFE_F00D);
    doRead(32'h0000_0004, 4'hF, 16'h0001, 8'h01, 3'd0, 2'd0, 0);
    chk(model[1] === 32'hCAFE_F00D, "R2 alias model", {32'd0, model[1]}, 64'hCAFEF00D);

    // R3 byte enables
    doWrite(32'h0000_0040, 4'hF, 32'hAABB_CCDD);
    doWrite(32'h0000_0040, 4'b0101, 32'h1122_3344);
    chk(model[16] === 32'hAA22_CC44, "R3 merge model", {32'd0, model[16]}, 64'hAA22CC44);
    doRead(32'h0000_0040, 4'b1000, 16'h7777, 8'hFE, 3'd7, 2'd3, 1);
    doRead(32'h0000_0040, 4'b0000, 16'h7778, 8'h02, 3'd1, 2'd2, 1);
    doRead(32'h0000_007C, 4'b0110, 16'h7779, 8'h03, 3'd1, 2'd2, 1);

    // R7 drops: length 2 write, bar miss, IO type, 4DW header, short remainder
    sendBeat({hdr0(7'h40, 0, 0, 10'd2), hdr1(16'h1, 8'h1, 4'hF)}, 8'h00, 1, 0);
    sendBeat({32'h0000_0040, 32'h0BAD_0001}, 8'h00, 0, 0);
    sendBeat({32'h0BAD_0002, 32'h0}, 8'h0F, 0, 1);
    expectQuiet("R7 bad length write");
    rxBarHitN = 7'b1111111;
    doWrite(32'h0000_0040, 4'hF, 32'h0BAD_0003);
    model[16] = 32'hAA22_CC44;
    rxBarHitN = 7'b1111101;
    sendBeat({hdr0(7'h42, 0, 0, 10'd1), hdr1(16'h1, 8'h1, 4'hF)}, 8'h00, 1, 0);
    sendBeat({32'h0000_0040, 32'h0BAD_0004}, 8'h00, 0, 1);
    sendBeat({hdr0(7'h60, 0, 0, 10'd1), hdr1(16'h1, 8'h1, 4'hF)}, 8'h00, 1, 0);
    sendBeat({32'h0, 32'h0000_0040}, 8'h00, 0, 0);
    sendBeat({32'h0BAD_0005, 32'h0}, 8'h0F, 0, 1);
    sendBeat({hdr0(7'h40, 0, 0, 10'd1), hdr1(16'h1, 8'h1, 4'hF)}, 8'h00, 1, 0);
    sendBeat({32'h0000_0040, 32'h0BAD_0006}, 8'h0F, 0, 1);
    expectQuiet("R7 dropped writes");
    sendBeat({hdr0(7'h00, 0, 0, 10'd2), hdr1(16'h1, 8'h1, 4'hF)}, 8'h00, 1, 0);
    sendBeat({32'h0000_0040, 32'h0}, 8'h0F, 0, 1);
    expectQuiet("R7 length 2 read");
    doRead(32'h0000_0040, 4'hF, 16'h4242, 8'h10, 3'd0, 2'd0, 0);

    // R1 link loss during a completion
    txDstRdyN = 1'b1;
    sendBeat({hdr0(7'h00, 0, 0, 10'd1), hdr1(16'h9, 8'h9, 4'hF)}, 8'h00, 1, 0);
    sendBeat({32'h0000_0040, 32'h0}, 8'h0F, 0, 1);
    chk(txSrcRdyN === 1'b0, "R1 completion started", {63'd0, txSrcRdyN}, 64'd0);
    linkUpN = 1'b1;
    @(negedge clk);
    chk(txSrcRdyN === 1'b1 && rxDstRdyN === 1'b0, "R1 link loss abandons", {62'd0, txSrcRdyN, rxDstRdyN}, 64'd2);
    linkUpN = 1'b0; txDstRdyN = 1'b0;
    @(negedge clk);
    doRead(32'h0000_0040, 4'hF, 16'h4243, 8'h11, 3'd0, 2'd0, 0);

    // random mix
    for (int k = 0; k < 150; k++) begin
      logic [31:0] a;
      a = (pool[$urandom % 64] & 32'h0000_1FFC) | ({$urandom} & 32'hFFFF_E000);
      complId = 16'($urandom);
      if ($urandom % 5 < 3) doWrite(a, 4'($urandom), $urandom);
      else doRead(a, 4'($urandom), 16'($urandom), 8'($urandom), 3'($urandom), 2'($urandom), 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule